// File: doc/BRIEF.md
# Pin Bank Controller with Per-Pin Interrupts

This block is a 32-pin general-purpose I/O bank controlled through a plain register port. The port has valid, write, address and data signals. Software writes an output value and a per-pin direction mask. Only pins marked as outputs drive their pad. The bank reads back the pad levels after they pass a synchronizer. Every pin also feeds an interrupt detector. For each pin, one register chooses between level and edge sensing, and a second register chooses the active sense.

Edge events are held in a per-pin latch until software writes a one to that pin's bit in the clear register. Level conditions are not latched: they follow the synchronized pin. A raw status register shows every pending condition. A masked status register shows only the conditions whose enable bit is set. A single interrupt output is the OR of the masked status bits.

Reads return data one clock after the request, on `rd_data`. Writes take effect at the clock edge that samples them.

Top module: `pinbank_gpio`

## Requirements
- R1: After reset the output data, direction and interrupt enable registers read 0, `pad_oe` is 0 and `irq` is 0.
- R2: The data register (offset 0x00) and direction register (offset 0x04) read back what was written. `pad_oe` equals the direction register, where a bit of 1 means output. `pad_out` equals the data register ANDed with the direction register.
- R3: The pad register (offset 0x50) returns the level of every pad after two synchronizer flops, whatever the pin's direction.
- R4: A pin whose sense-type bit (offset 0x38) is 0 is level sensed. Its raw status bit (offset 0x44) is 1 while the synchronized pad equals its polarity bit (offset 0x3C). Polarity 1 means active high and polarity 0 means active low.
- R5: A pin whose sense-type bit is 1 with polarity 1 latches a rising transition of the synchronized pad into its raw status bit. A falling transition does not set the bit, and the bit stays set after the pad returns.
- R6: A pin whose sense-type bit is 1 with polarity 0 latches a falling transition. A rising transition does not set the bit.
- R7: Writing 1 to a bit of the clear register (offset 0x4C) clears that pin's latched edge event from the next cycle on. Writing 0 to a bit leaves that pin's latched edge event unchanged. The clear register reads as 0.
- R8: A write to the clear register does not change the raw status of a level-sensed pin.
- R9: The masked status (offset 0x40) equals the raw status ANDed with the enable register (offset 0x30). Edge events are latched even while the pin is disabled.
- R10: If an edge event and a clear write to the same pin fall in the same cycle, the event stays latched.
- R11: `irq` is 1 exactly when at least one masked status bit is 1.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address of the register, word aligned |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid one cycle after a read request |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Level driven onto the pads |
| pad_oe | output | 32 | Per-pad output enable |
| irq | output | 1 | Combined interrupt line |

## Verification
The bench builds the bank with its default parameters: 32 pins, an 8-bit address and a two-flop synchronizer. With these values the full register map and the full data width are covered. The fixed synchronizer depth lets the bench place a clear write in exactly the cycle where a pad transition is detected, which is the only way to reach the case where the event and the clear collide. Pins 0 to 5 carry the interrupt scenarios, one scenario per sensing mode and polarity. The upper pins, set to edge sense with a quiet pad, confirm that idle pins raise nothing.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_DOUT  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_SENSE = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_POL   = 8'h3C;
  localparam logic [ADDR_W-1:0] OFS_MSTAT = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_RSTAT = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h4C;
  localparam logic [ADDR_W-1:0] OFS_PADS  = 8'h50;

  // level condition: pin equals its polarity bit
  function automatic logic [31:0] level_hit(input logic [31:0] cur,
                                            input logic [31:0] pol);
    return ~(cur ^ pol);
  endfunction

  // edge condition: rising when polarity 1, falling when polarity 0
  function automatic logic [31:0] edge_hit(input logic [31:0] cur,
                                           input logic [31:0] prv,
                                           input logic [31:0] pol);
    return (cur & ~prv & pol) | (~cur & prv & ~pol);
  endfunction

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/pinbank_detect.sv
module pinbank_detect
  import pinbank_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_lvl,
  input  logic [W-1:0] sense_edge,
  input  logic [W-1:0] polarity,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] edge_evt,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] raw_stat
);

  logic [W-1:0] prev_q;
  logic [W-1:0] lvl_cond;
  logic [W-1:0] edg_cond;
  logic [31:0]  cur_x, prv_x, pol_x, lvl_x, edg_x;

  assign cur_x = 32'(pin_lvl);
  assign prv_x = 32'(prev_q);
  assign pol_x = 32'(polarity);
  assign lvl_x = level_hit(cur_x, pol_x);
  assign edg_x = edge_hit(cur_x, prv_x, pol_x);

  assign lvl_cond = lvl_x[W-1:0];
  assign edg_cond = edg_x[W-1:0];

  assign edge_evt = edg_cond & sense_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= pin_lvl;
      // a fresh event overrides a simultaneous clear
      latch_q <= ((latch_q & ~clr_mask) | edge_evt) & sense_edge;
    end
  end

  assign raw_stat = (lvl_cond & ~sense_edge) | (latch_q & sense_edge);

endmodule

// File: rtl/pinbank_gpio.sv
module pinbank_gpio
  import pinbank_pkg::*;
#(
  parameter int unsigned NPINS       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [NPINS-1:0]  req_wdata,
  output logic [NPINS-1:0]  rd_data,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq
);

  logic [NPINS-1:0] dout_q, dir_q, ien_q, sense_q, pol_q;
  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] edge_evt, latch_q, raw_stat, msk_stat;
  logic [NPINS-1:0] clr_pulse;
  logic             wr_en, rd_en;

  assign wr_en = req_valid && req_write;
  assign rd_en = req_valid && !req_write;

  assign clr_pulse = (wr_en && req_addr == OFS_CLR) ? req_wdata : '0;

  pinbank_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(pad_in),
    .sync_out(pin_sync)
  );

  pinbank_detect #(.W(NPINS)) u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_lvl   (pin_sync),
    .sense_edge(sense_q),
    .polarity  (pol_q),
    .clr_mask  (clr_pulse),
    .edge_evt  (edge_evt),
    .latch_q   (latch_q),
    .raw_stat  (raw_stat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q  <= '0;
      dir_q   <= '0;
      ien_q   <= '0;
      sense_q <= '0;
      pol_q   <= '0;
    end else if (wr_en) begin
      unique case (req_addr)
        OFS_DOUT:  dout_q  <= req_wdata;
        OFS_DIR:   dir_q   <= req_wdata;
        OFS_IEN:   ien_q   <= req_wdata;
        OFS_SENSE: sense_q <= req_wdata;
        OFS_POL:   pol_q   <= req_wdata;
        default:   ;
      endcase
    end
  end

  assign msk_stat = raw_stat & ien_q;
  assign irq      = |msk_stat;
  assign pad_oe   = dir_q;
  assign pad_out  = dout_q & dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      unique case (req_addr)
        OFS_DOUT:  rd_data <= dout_q;
        OFS_DIR:   rd_data <= dir_q;
        OFS_IEN:   rd_data <= ien_q;
        OFS_SENSE: rd_data <= sense_q;
        OFS_POL:   rd_data <= pol_q;
        OFS_MSTAT: rd_data <= msk_stat;
        OFS_RSTAT: rd_data <= raw_stat;
        OFS_PADS:  rd_data <= pin_sync;
        default:   rd_data <= '0;
      endcase
    end
  end

endmodule

module pinbank_gpio_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] pad_oe,
  input logic         irq,
  input logic [W-1:0] ien_q,
  input logic [W-1:0] clr_pulse,
  input logic [W-1:0] edge_evt,
  input logic [W-1:0] latch_q
);

  // R2
  oe_gates_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);

  // R11
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien_q != '0));

  // R7
  clear_drops_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_pulse & ~edge_evt) != '0) |=> ((latch_q & $past(clr_pulse & ~edge_evt)) == '0));

  // R10
  event_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt != '0) |=> ((latch_q & $past(edge_evt)) == $past(edge_evt)));

endmodule

bind pinbank_gpio pinbank_gpio_chk #(.W(NPINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe),
  .irq      (irq),
  .ien_q    (ien_q),
  .clr_pulse(clr_pulse),
  .edge_evt (edge_evt),
  .latch_q  (latch_q)
);

// File: tb/pinbank_gpio_test.sv
module pinbank_gpio_test;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_write = 0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 0;

  always #5 clk = ~clk;

  pinbank_gpio uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  // driver: issues the read and pushes the expected value
  task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // monitor: pops and compares once the read data is registered
  initial begin
    forever begin
      @(posedge clk);
      if (req_valid && !req_write) begin
        @(negedge clk);
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    rd(8'h00, 32'h0, "R1 data reset");
    rd(8'h04, 32'h0, "R1 dir reset");
    rd(8'h30, 32'h0, "R1 enable reset");
    check("R1 pad_oe reset", pad_oe, 32'h0);
    check("R1 irq reset", {31'h0, irq}, 32'h0);

    // R2
    wr(8'h00, 32'hA5A5_F00F);
    wr(8'h04, 32'hFFFF_0000);
    rd(8'h00, 32'hA5A5_F00F, "R2 data readback");
    rd(8'h04, 32'hFFFF_0000, "R2 dir readback");
    check("R2 pad_oe", pad_oe, 32'hFFFF_0000);
    check("R2 pad_out gated", pad_out, 32'hA5A5_0000);

    // R3
    pad_in = 32'h1234_5678;
    settle();
    rd(8'h50, 32'h1234_5678, "R3 pad levels");
    pad_in = 32'h0;
    settle();
    rd(8'h50, 32'h0, "R3 pad levels low");

    // configure: pin0 level, the rest edge
    wr(8'h38, 32'hFFFF_FFFE);
    wr(8'h3C, 32'h0000_003B);
    rd(8'h44, 32'h0, "R5 idle raw");

    // R4
    pad_in[0] = 1; settle();
    rd(8'h44, 32'h1, "R4 level high active");
    pad_in[0] = 0; settle();
    rd(8'h44, 32'h0, "R4 level high inactive");
    wr(8'h3C, 32'h0000_003A);
    rd(8'h44, 32'h1, "R4 level low active");
    wr(8'h3C, 32'h0000_003B);

    // R5
    pad_in[1] = 1; settle();
    rd(8'h44, 32'h2, "R5 rising latched");
    pad_in[1] = 0; settle();
    rd(8'h44, 32'h2, "R5 latch held");

    // R6
    pad_in[2] = 1; settle();
    rd(8'h44, 32'h2, "R6 rising ignored");
    pad_in[2] = 0; settle();
    rd(8'h44, 32'h6, "R6 falling latched");

    // R7
    wr(8'h4C, 32'h0);
    rd(8'h44, 32'h6, "R7 zero write no effect");
    wr(8'h4C, 32'h2);
    rd(8'h44, 32'h4, "R7 clear one pin");
    rd(8'h4C, 32'h0, "R7 clear reads zero");
    wr(8'h4C, 32'h4);
    rd(8'h44, 32'h0, "R7 clear second pin");

    // R8
    pad_in[0] = 1; settle();
    wr(8'h4C, 32'h1);
    rd(8'h44, 32'h1, "R8 level unaffected");
    pad_in[0] = 0; settle();

    // R9 / R11
    pad_in[3] = 1; settle();
    rd(8'h44, 32'h8, "R9 latched while disabled");
    rd(8'h40, 32'h0, "R9 masked zero");
    check("R11 irq low when masked", {31'h0, irq}, 32'h0);
    wr(8'h30, 32'h8);
    rd(8'h40, 32'h8, "R9 masked pass");
    check("R11 irq high", {31'h0, irq}, 32'h1);
    wr(8'h30, 32'h10);
    rd(8'h40, 32'h0, "R9 other pin enabled");
    check("R11 irq low other enable", {31'h0, irq}, 32'h0);
    wr(8'h4C, 32'h8);

    // R10
    pad_in[4] = 1; settle();
    check("R11 irq from pin4", {31'h0, irq}, 32'h1);
    pad_in[4] = 0; settle();
    @(negedge clk);
    pad_in[4] = 1;
    @(negedge clk);
    wr(8'h4C, 32'h10);
    rd(8'h44, 32'h10, "R10 event beats clear");
    wr(8'h4C, 32'h10);
    rd(8'h44, 32'h0, "R7 plain clear after collision");
    check("R11 irq cleared", {31'h0, irq}, 32'h0);

    settle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule